// File: doc/BRIEF.md
# Instruction Byte-Stream Field Decoder

This block accepts a stream of 16-bit-mode machine instruction bytes, one per valid/ready handshake. It separates each instruction into its fields and collects the trailing displacement and immediate bytes. It then presents one decoded record. The first byte supplies a six-bit operation code, a direction flag and a width flag. The second byte is the mode byte. It carries a two-bit addressing mode, a three-bit register code and a three-bit register-or-memory code. The mode and the register-or-memory code decide how many displacement bytes follow. The opcode and the width flag decide how many immediate bytes follow.

Two instruction families are recognised: the register/memory move and the immediate-to-memory move. Any other leading byte is rejected with a one-cycle illegal pulse, and the decoder then waits for a fresh opcode byte. A completed instruction raises a one-cycle done pulse together with the record. The record holds the operation class, the register names, the displacement, the immediate and the total byte length. It keeps these values until the next completed instruction.

Top module: `insn_field_dec`

## Requirements
- R1: `byte_ready_o` is low in reset and high afterwards. A byte is consumed on each rising edge where valid and ready are both high. While valid is low, nothing is consumed and the record outputs do not change.
- R2: A first byte whose bits 7:2 are 100010 starts a register/memory move. It reports `op_class_o` = 1, `dir_o` = bit 1 (1 means the register field is the destination) and `wide_o` = bit 0 (1 means word).
- R3: A first byte whose bits 7:1 are 1100011 starts an immediate-to-memory move and reports `op_class_o` = 2. Its mode byte must have bits 5:3 equal to 000. Any other value makes the instruction illegal.
- R4: The mode byte is split into mode (bits 7:6), register code (bits 5:3) and register-or-memory code (bits 2:0). `reg_name_o` = {W, register code}. Names 0 to 7 are AL, CL, DL, BL, AH, CH, DH, BH and names 8 to 15 are AX, CX, DX, BX, SP, BP, SI, DI.
- R5: Mode 11 means the register-or-memory code names a register. In that case `rm_is_reg_o` = 1, `rm_name_o` = {W, code}, no displacement byte follows and `disp_o` = 0.
- R6: Mode 00 with a code other than 110 takes no displacement byte. It gives `disp_o` = 0, `rm_is_reg_o` = 0 and `rm_name_o` = {0, code}.
- R7: Mode 01 takes one displacement byte, sign-extended to 16 bits.
- R8: Mode 10 takes two displacement bytes, low byte first. Mode 00 with code 110 also takes two bytes, low byte first, and is a direct address with `direct_o` = 1. Neither case applies sign extension.
- R9: An immediate move takes one immediate byte when W = 0, zero-extended to 16 bits. It takes two bytes, low byte first, when W = 1. Immediate bytes follow all displacement bytes. A register/memory move reports `imm_o` = 0.
- R10: `done_o` is high for exactly one cycle, starting at the clock edge that consumes the last byte of an instruction. `len_o` = 2 + displacement bytes + immediate bytes. The record outputs change only on that edge.
- R11: An unknown first byte raises `illegal_o` for one cycle, starting at the edge that consumes it. The same happens at the mode byte when the immediate move's register field is not 000. Neither case raises `done_o` or changes the record. The next byte is treated as an opcode.
- R12: In reset, `done_o` and `illegal_o` are low and all record outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| byte_valid_i | input | 1 | Input byte is valid |
| byte_i | input | 8 | Instruction byte |
| byte_ready_o | output | 1 | Decoder accepts a byte |
| done_o | output | 1 | One-cycle pulse: record updated |
| illegal_o | output | 1 | One-cycle pulse: instruction rejected |
| op_class_o | output | 2 | 0 none, 1 register/memory move, 2 immediate move |
| dir_o | output | 1 | Direction flag |
| wide_o | output | 1 | Word operand flag |
| mode_o | output | 2 | Addressing mode field |
| reg_name_o | output | 4 | Register operand name |
| rm_is_reg_o | output | 1 | Register-or-memory field names a register |
| rm_name_o | output | 4 | Register name, or {0, memory code} |
| direct_o | output | 1 | Direct-address form |
| disp_o | output | 16 | Displacement, extended |
| imm_o | output | 16 | Immediate, extended |
| len_o | output | 3 | Instruction length in bytes |

## Verification
The bench targets the direct-address exception (mode 00, code 110). A decoder that misses it would end the instruction after two bytes and read the address bytes as new opcodes. It also drives an 8-bit displacement of 0x80 next to mode 00 with code 110 and a negative two-byte address. These catch missing or misplaced sign extension.

Byte immediates above 0x7F expose sign extension where zero extension is required. A wrong register field on the immediate move, and a neighbouring opcode just outside the move family, must both be rejected. After each rejection the bench expects the following byte to decode as an opcode. It also expects the held record to be unchanged.

Valid-low gaps inside an instruction check that idle cycles neither consume bytes nor disturb the held record.

// File: rtl/insn_dec_pkg.sv
package insn_dec_pkg;
  localparam int BYTE_W = 8;
  localparam int WORD_W = 2 * BYTE_W;
  localparam int CODE_W = 3;
  localparam int NAME_W = CODE_W + 1;
  localparam int LEN_W  = 3;
  localparam int CNT_W  = 2;

  localparam logic [5:0]        OPC_MOVE   = 6'b100010;
  localparam logic [6:0]        OPC_MOVI   = 7'b1100011;
  localparam logic [CODE_W-1:0] RM_DIRECT  = 3'b110;

  typedef enum logic [1:0] {
    CLS_NONE = 2'd0,
    CLS_MOVE = 2'd1,
    CLS_MOVI = 2'd2
  } op_class_e;

  typedef enum logic [1:0] {
    ST_OP, ST_MODRM, ST_DISP, ST_IMM
  } dec_state_e;

  typedef struct packed {
    op_class_e          cls;
    logic               dir;
    logic               wide;
    logic [1:0]         mode;
    logic [NAME_W-1:0]  reg_name;
    logic               rm_is_reg;
    logic [NAME_W-1:0]  rm_name;
    logic               direct;
    logic [WORD_W-1:0]  disp;
    logic [WORD_W-1:0]  imm;
    logic [LEN_W-1:0]   len;
  } dec_rec_t;
endpackage

// File: rtl/insn_dec_len.sv
module insn_dec_len
  import insn_dec_pkg::*;
(
  input  logic [1:0]        mode_i,
  input  logic [CODE_W-1:0] rm_i,
  input  logic              is_movi_i,
  input  logic              wide_i,
  output logic [CNT_W-1:0]  disp_n_o,
  output logic [CNT_W-1:0]  imm_n_o,
  output logic              direct_o,
  output logic              rm_is_reg_o
);
  assign direct_o    = (mode_i == 2'b00) && (rm_i == RM_DIRECT);
  assign rm_is_reg_o = (mode_i == 2'b11);

  always_comb begin
    unique case (mode_i)
      2'b00:   disp_n_o = direct_o ? CNT_W'(2) : CNT_W'(0);
      2'b01:   disp_n_o = CNT_W'(1);
      2'b10:   disp_n_o = CNT_W'(2);
      default: disp_n_o = CNT_W'(0);
    endcase
  end

  assign imm_n_o = !is_movi_i ? CNT_W'(0) : (wide_i ? CNT_W'(2) : CNT_W'(1));
endmodule

// File: rtl/insn_dec_regname.sv
module insn_dec_regname #(
  parameter int CODE_W = 3
) (
  input  logic              wide_i,
  input  logic [CODE_W-1:0] code_i,
  output logic [CODE_W:0]   name_o
);
  // byte bank occupies names 0..7, word bank 8..15
  assign name_o = {wide_i, code_i};
endmodule

// File: rtl/insn_dec_core.sv
module insn_dec_core
  import insn_dec_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              byte_valid_i,
  input  logic [BYTE_W-1:0] byte_i,
  output logic              byte_ready_o,
  output logic              fin_o,
  output logic              bad_o,
  output dec_rec_t          rec_o
);
  dec_state_e        state_q, state_d;
  logic [BYTE_W-1:0] op_q, op_d, modrm_q, modrm_d;
  logic [WORD_W-1:0] disp_q, disp_d, imm_q, imm_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              lo_q, lo_d;
  logic              ready_q;

  logic              acc;
  logic [BYTE_W-1:0] mode_src;
  logic              is_move_b, is_movi_b, is_movi_q;
  logic [CNT_W-1:0]  disp_n, imm_n;
  logic              direct, rm_is_reg;
  logic [NAME_W-1:0] reg_name, rm_name;

  assign acc          = byte_valid_i && ready_q;
  assign byte_ready_o = ready_q;
  assign is_move_b    = (byte_i[7:2] == OPC_MOVE);
  assign is_movi_b    = (byte_i[7:1] == OPC_MOVI);
  assign is_movi_q    = (op_q[7:1] == OPC_MOVI);
  // mode byte is live on the input during its own cycle
  assign mode_src     = (state_q == ST_MODRM) ? byte_i : modrm_q;

  insn_dec_len u_len (
    .mode_i      (mode_src[7:6]),
    .rm_i        (mode_src[CODE_W-1:0]),
    .is_movi_i   (is_movi_q),
    .wide_i      (op_q[0]),
    .disp_n_o    (disp_n),
    .imm_n_o     (imm_n),
    .direct_o    (direct),
    .rm_is_reg_o (rm_is_reg)
  );

  insn_dec_regname #(.CODE_W(CODE_W)) u_reg_name (
    .wide_i (op_q[0]),
    .code_i (modrm_d[5:3]),
    .name_o (reg_name)
  );

  insn_dec_regname #(.CODE_W(CODE_W)) u_rm_name (
    .wide_i (op_q[0] & rm_is_reg),
    .code_i (modrm_d[CODE_W-1:0]),
    .name_o (rm_name)
  );

  always_comb begin
    state_d = state_q;
    op_d    = op_q;
    modrm_d = modrm_q;
    disp_d  = disp_q;
    imm_d   = imm_q;
    cnt_d   = cnt_q;
    lo_d    = lo_q;
    fin_o   = 1'b0;
    bad_o   = 1'b0;
    if (acc) begin
      unique case (state_q)
        ST_OP: begin
          if (is_move_b || is_movi_b) begin
            op_d    = byte_i;
            disp_d  = '0;
            imm_d   = '0;
            state_d = ST_MODRM;
          end else begin
            bad_o = 1'b1;
          end
        end
        ST_MODRM: begin
          modrm_d = byte_i;
          if (is_movi_q && (byte_i[5:3] != 3'b000)) begin
            bad_o   = 1'b1;
            state_d = ST_OP;
          end else if (disp_n != '0) begin
            state_d = ST_DISP;
            cnt_d   = disp_n;
            lo_d    = 1'b1;
          end else if (imm_n != '0) begin
            state_d = ST_IMM;
            cnt_d   = imm_n;
            lo_d    = 1'b1;
          end else begin
            fin_o   = 1'b1;
            state_d = ST_OP;
          end
        end
        ST_DISP: begin
          // low byte lands sign-extended; a high byte overwrites the top half
          if (lo_q) disp_d = {{BYTE_W{byte_i[BYTE_W-1]}}, byte_i};
          else      disp_d = {byte_i, disp_q[BYTE_W-1:0]};
          lo_d  = 1'b0;
          cnt_d = cnt_q - CNT_W'(1);
          if (cnt_q == CNT_W'(1)) begin
            if (imm_n != '0) begin
              state_d = ST_IMM;
              cnt_d   = imm_n;
              lo_d    = 1'b1;
            end else begin
              fin_o   = 1'b1;
              state_d = ST_OP;
            end
          end
        end
        default: begin
          if (lo_q) imm_d = {{BYTE_W{1'b0}}, byte_i};
          else      imm_d = {byte_i, imm_q[BYTE_W-1:0]};
          lo_d  = 1'b0;
          cnt_d = cnt_q - CNT_W'(1);
          if (cnt_q == CNT_W'(1)) begin
            fin_o   = 1'b1;
            state_d = ST_OP;
          end
        end
      endcase
    end
  end

  always_comb begin
    rec_o.cls       = is_movi_q ? CLS_MOVI : CLS_MOVE;
    rec_o.dir       = op_q[1];
    rec_o.wide      = op_q[0];
    rec_o.mode      = modrm_d[7:6];
    rec_o.reg_name  = reg_name;
    rec_o.rm_is_reg = rm_is_reg;
    rec_o.rm_name   = rm_name;
    rec_o.direct    = direct;
    rec_o.disp      = disp_d;
    rec_o.imm       = imm_d;
    rec_o.len       = LEN_W'(2) + LEN_W'(disp_n) + LEN_W'(imm_n);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_OP;
      op_q    <= '0;
      modrm_q <= '0;
      disp_q  <= '0;
      imm_q   <= '0;
      cnt_q   <= '0;
      lo_q    <= 1'b0;
      ready_q <= 1'b0;
    end else begin
      state_q <= state_d;
      op_q    <= op_d;
      modrm_q <= modrm_d;
      disp_q  <= disp_d;
      imm_q   <= imm_d;
      cnt_q   <= cnt_d;
      lo_q    <= lo_d;
      ready_q <= 1'b1;
    end
  end

  p_cnt_live_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_DISP || state_q == ST_IMM) |-> (cnt_q != '0));

  p_no_accept_in_reset_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ready_q |=> (state_q == ST_OP));
endmodule

// File: rtl/insn_field_dec.sv
module insn_field_dec
  import insn_dec_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               byte_valid_i,
  input  logic [BYTE_W-1:0]  byte_i,
  output logic               byte_ready_o,
  output logic               done_o,
  output logic               illegal_o,
  output logic [1:0]         op_class_o,
  output logic               dir_o,
  output logic               wide_o,
  output logic [1:0]         mode_o,
  output logic [NAME_W-1:0]  reg_name_o,
  output logic               rm_is_reg_o,
  output logic [NAME_W-1:0]  rm_name_o,
  output logic               direct_o,
  output logic [WORD_W-1:0]  disp_o,
  output logic [WORD_W-1:0]  imm_o,
  output logic [LEN_W-1:0]   len_o
);
  logic     fin, bad;
  dec_rec_t rec_nx, rec_q;
  logic     done_q, bad_q;

  insn_dec_core u_core (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .byte_valid_i (byte_valid_i),
    .byte_i       (byte_i),
    .byte_ready_o (byte_ready_o),
    .fin_o        (fin),
    .bad_o        (bad),
    .rec_o        (rec_nx)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rec_q  <= '0;
      done_q <= 1'b0;
      bad_q  <= 1'b0;
    end else begin
      done_q <= fin;
      bad_q  <= bad;
      if (fin) rec_q <= rec_nx;
    end
  end

  assign done_o      = done_q;
  assign illegal_o   = bad_q;
  assign op_class_o  = rec_q.cls;
  assign dir_o       = rec_q.dir;
  assign wide_o      = rec_q.wide;
  assign mode_o      = rec_q.mode;
  assign reg_name_o  = rec_q.reg_name;
  assign rm_is_reg_o = rec_q.rm_is_reg;
  assign rm_name_o   = rec_q.rm_name;
  assign direct_o    = rec_q.direct;
  assign disp_o      = rec_q.disp;
  assign imm_o       = rec_q.imm;
  assign len_o       = rec_q.len;

  p_done_illegal_excl_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && illegal_o));

  p_done_pulse_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_rec_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> ($stable(disp_o) && $stable(imm_o) && $stable(len_o) && $stable(reg_name_o)));

  p_len_range_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (len_o >= LEN_W'(2) && len_o <= LEN_W'(6)));

  p_short_disp_sext_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && mode_o == 2'b01) |-> (disp_o[WORD_W-1:BYTE_W] == {BYTE_W{disp_o[BYTE_W-1]}}));

  p_no_disp_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !direct_o && (mode_o == 2'b00 || mode_o == 2'b11)) |-> (disp_o == '0));

  p_move_no_imm_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && op_class_o == 2'(CLS_MOVE)) |-> (imm_o == '0));

  p_movi_reg_zero_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && op_class_o == 2'(CLS_MOVI)) |-> (reg_name_o[CODE_W-1:0] == '0));
endmodule

// File: tb/insn_field_dec_tb.sv
module insn_field_dec_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic valid = 1'b0;
  logic [7:0] bval = 8'h00;

  logic        ready, done, illegal, dir, wide, rm_is_reg, direct;
  logic [1:0]  op_class, mode;
  logic [3:0]  reg_name, rm_name;
  logic [15:0] disp, imm;
  logic [2:0]  len;

  always #5 clk = ~clk;

  insn_field_dec u_dut (
    .clk_i(clk), .rst_ni(rst_n), .byte_valid_i(valid), .byte_i(bval),
    .byte_ready_o(ready), .done_o(done), .illegal_o(illegal),
    .op_class_o(op_class), .dir_o(dir), .wide_o(wide), .mode_o(mode),
    .reg_name_o(reg_name), .rm_is_reg_o(rm_is_reg), .rm_name_o(rm_name),
    .direct_o(direct), .disp_o(disp), .imm_o(imm), .len_o(len)
  );

  typedef struct {
    bit          bad;
    logic [1:0]  cls;
    logic        dir, wide;
    logic [1:0]  mode;
    logic [3:0]  rn;
    logic        rmr;
    logic [3:0]  rmn;
    logic        drc;
    logic [15:0] dsp, imv;
    logic [2:0]  ln;
  } exp_t;

  exp_t q[$];
  int tests = 0;
  int fails = 0;
  int hold_bad = 0;
  bit running = 1'b0;
  logic [50:0] last_rec = '0;

  function automatic logic [50:0] rec_vec();
    return {op_class, dir, wide, mode, reg_name, rm_is_reg, rm_name, direct, disp, imm, len};
  endfunction

  function automatic exp_t mk(input logic [1:0] c, input logic d, input logic w, input logic [1:0] m,
                              input logic [3:0] rn, input logic rr, input logic [3:0] rm,
                              input logic dr, input logic [15:0] ds, input logic [15:0] im,
                              input logic [2:0] ln);
    exp_t e;
    e.bad = 1'b0; e.cls = c; e.dir = d; e.wide = w; e.mode = m; e.rn = rn; e.rmr = rr;
    e.rmn = rm; e.drc = dr; e.dsp = ds; e.imv = im; e.ln = ln;
    return e;
  endfunction

  function automatic exp_t mk_bad();
    exp_t e;
    e = mk(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    e.bad = 1'b1;
    return e;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && running) begin
      if (done || illegal) begin
        if (q.size() == 0) begin
          chk(1'b0, "R11", "unexpected pulse", {done, illegal}, 0);
        end else begin
          exp_t e;
          e = q.pop_front();
          if (e.bad) begin
            chk(illegal && !done, "R11", "illegal without done", {done, illegal}, 1);
            chk(rec_vec() == last_rec, "R11", "record untouched", 0, 0);
          end else begin
            chk(done && !illegal, "R10", "done without illegal", {done, illegal}, 2);
            chk(op_class == e.cls, e.cls == 2 ? "R3" : "R2", "class", op_class, e.cls);
            chk(dir == e.dir && wide == e.wide, "R2", "dir/wide", {dir, wide}, {e.dir, e.wide});
            chk(mode == e.mode, "R4", "mode", mode, e.mode);
            chk(reg_name == e.rn, "R4", "reg_name", reg_name, e.rn);
            chk(rm_is_reg == e.rmr && rm_name == e.rmn, e.rmr ? "R5" : "R6", "rm",
                {rm_is_reg, rm_name}, {e.rmr, e.rmn});
            chk(direct == e.drc, "R8", "direct", direct, e.drc);
            chk(disp == e.dsp, e.mode == 2'b01 ? "R7" : "R8", "disp", disp, e.dsp);
            chk(imm == e.imv, "R9", "imm", imm, e.imv);
            chk(len == e.ln, "R10", "len", len, e.ln);
            last_rec = rec_vec();
          end
        end
      end else if (rec_vec() != last_rec) begin
        hold_bad++;
        $display("FAIL R1 record changed without done actual=%0h expected=%0h", rec_vec(), last_rec);
      end
    end
  end

  // driver
  task automatic send(input logic [7:0] bs[6], input int n, input exp_t e, input int gap, input string req);
    q.push_back(e);
    for (int i = 0; i < n; i++) begin
      if (i > 0) begin
        for (int g = 0; g < gap; g++) begin
          valid = 1'b0;
          @(negedge clk);
        end
      end
      valid = 1'b1;
      bval  = bs[i];
      @(negedge clk);
    end
    valid = 1'b0;
    if (e.bad) chk(illegal == 1'b1, "R11", {"illegal latency ", req}, illegal, 1);
    else       chk(done == 1'b1, "R10", {"done latency ", req}, done, 1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", q.size(), 0);
    $display("  [TB] %0d tests run, %0d failed", tests + 1, fails);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    // R12 reset state
    chk(!done && !illegal, "R12", "pulses low in reset", {done, illegal}, 0);
    chk(rec_vec() == '0, "R12", "record zero in reset", 32'(rec_vec()), 0);
    chk(ready == 1'b0, "R1", "ready low in reset", ready, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(ready == 1'b1, "R1", "ready after reset", ready, 1);
    running = 1'b1;

    // R5: 8B EC -> BP <- SP word
    send('{8'h8B, 8'hEC, 0, 0, 0, 0}, 2, mk(1, 1, 1, 3, 13, 1, 12, 0, 16'h0000, 0, 2), 0, "R5");
    // R6: 8A 15 -> DL <- [DI]
    send('{8'h8A, 8'h15, 0, 0, 0, 0}, 2, mk(1, 1, 0, 0, 2, 0, 5, 0, 16'h0000, 0, 2), 0, "R6");
    // R7: negative short displacement
    send('{8'h88, 8'h47, 8'hFE, 0, 0, 0}, 3, mk(1, 0, 0, 1, 0, 0, 7, 0, 16'hFFFE, 0, 3), 0, "R7");
    send('{8'h89, 8'h47, 8'h05, 0, 0, 0}, 3, mk(1, 0, 1, 1, 8, 0, 7, 0, 16'h0005, 0, 3), 0, "R7");
    // R7: mode 01 with code 110 is not direct
    send('{8'h8B, 8'h46, 8'h80, 0, 0, 0}, 3, mk(1, 1, 1, 1, 8, 0, 6, 0, 16'hFF80, 0, 3), 0, "R7");
    // R8: direct address, then negative direct (no extension)
    send('{8'h8B, 8'h1E, 8'h00, 8'h10, 0, 0}, 4, mk(1, 1, 1, 0, 11, 0, 6, 1, 16'h1000, 0, 4), 0, "R8");
    send('{8'h8B, 8'h06, 8'h34, 8'h92, 0, 0}, 4, mk(1, 1, 1, 0, 8, 0, 6, 1, 16'h9234, 0, 4), 0, "R8");
    // R8 + R1: mode 10 with stall gaps
    send('{8'h89, 8'h97, 8'h34, 8'h12, 0, 0}, 4, mk(1, 0, 1, 2, 10, 0, 7, 0, 16'h1234, 0, 4), 2, "R1");
    // R9: six-byte word immediate
    send('{8'hC7, 8'h87, 8'h00, 8'h10, 8'h34, 8'h12}, 6, mk(2, 1, 1, 2, 8, 0, 7, 0, 16'h1000, 16'h1234, 6), 0, "R9");
    // R9: byte immediate after direct address
    send('{8'hC6, 8'h06, 8'h20, 8'h00, 8'h7F, 0}, 5, mk(2, 1, 0, 0, 0, 0, 6, 1, 16'h0020, 16'h007F, 5), 0, "R9");
    // R9: byte immediate >0x7F zero-extended, register target
    send('{8'hC6, 8'hC3, 8'hAB, 0, 0, 0}, 3, mk(2, 1, 0, 3, 0, 1, 3, 0, 16'h0000, 16'h00AB, 3), 0, "R9");
    // R9 + R1: word immediate, direct, with gaps
    send('{8'hC7, 8'h06, 8'hFE, 8'hFF, 8'h80, 8'h00}, 6, mk(2, 1, 1, 0, 8, 0, 6, 1, 16'hFFFE, 16'h0080, 6), 1, "R9");
    // R11: unknown opcode, then recovery
    send('{8'h90, 0, 0, 0, 0, 0}, 1, mk_bad(), 0, "R11");
    send('{8'h8A, 8'hC4, 0, 0, 0, 0}, 2, mk(1, 1, 0, 3, 0, 1, 4, 0, 16'h0000, 0, 2), 0, "R11");
    // R11: neighbour opcode outside the move family
    send('{8'h8C, 0, 0, 0, 0, 0}, 1, mk_bad(), 0, "R11");
    // R3: immediate move with nonzero register field
    send('{8'hC7, 8'h48, 0, 0, 0, 0}, 2, mk_bad(), 0, "R3");
    send('{8'h89, 8'hD8, 0, 0, 0, 0}, 2, mk(1, 0, 1, 3, 11, 1, 8, 0, 16'h0000, 0, 2), 0, "R4");

    repeat (4) @(negedge clk);
    running = 1'b0;
    chk(q.size() == 0, "R10", "all expected records seen", q.size(), 0);
    chk(hold_bad == 0, "R1", "record held between done pulses", hold_bad, 0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule